// File: doc/BRIEF.md
# Wide-dividend integer divider with divide-error detection

This block divides a double-width dividend, supplied as an upper and a lower word, by a single-width divisor. It produces a single-width quotient and remainder in either unsigned or two's-complement signed arithmetic. The caller pulses `start` with the operands present and waits for `done`. A `fault` flag rises in the same cycle as `done` when the result cannot be represented. In that case the quotient and remainder outputs keep their previous values, so nothing is committed.

Faults that can be seen from the operands alone are resolved one cycle after the start is taken. These are a zero divisor, an upper dividend word that is not below the divisor, and the most negative signed dividend. All other operations run an iterative restoring divider over the operand magnitudes, one quotient bit per cycle. A final cycle then applies the signs and checks the signed quotient range. Signed division truncates toward zero.

Top module: `wide_divider`

## Requirements
- R1: The dividend is {dividend_hi, dividend_lo}, with dividend_hi in bits 63:32. In unsigned mode (signed_mode=0) a successful operation drives quotient = floor(dividend/divisor) and remainder = dividend mod divisor.
- R2: A divisor of zero raises fault, in both unsigned and signed mode.
- R3: In unsigned mode, fault is raised exactly when the quotient would need more than 32 bits, which is when dividend_hi >= divisor.
- R4: In signed mode, a dividend of 0x8000000000000000 raises fault, whatever the divisor, including a zero divisor.
- R5: In signed mode, fault is raised when the true quotient is above 0x7FFFFFFF or below -0x80000000. A quotient of exactly -0x80000000 is delivered without fault.
- R6: In signed mode (signed_mode=1) the quotient is truncated toward zero. The remainder carries the sign of the dividend and has a magnitude below that of the divisor.
- R7: When fault is high, quotient and remainder keep the values they held before the operation.
- R8: fault is only ever high together with done. Count the edge that samples start as edge 1. For the faults of R2, R3 and R4, done and fault are high after edge 2.
- R9: Every operation that does not fault early has done high after edge 35 (width + 3). This covers successful results and the range faults of R5.
- R10: A start asserted while an operation is in progress is ignored. It has no effect on the running operation's operands, result or timing.
- R11: done and fault are single-cycle pulses. After reset, quotient and remainder are zero and done and fault are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation, taken only when idle |
| signed_mode | input | 1 | 1 = two's-complement signed, 0 = unsigned |
| dividend_hi | input | 32 | Upper word of the dividend |
| dividend_lo | input | 32 | Lower word of the dividend |
| divisor | input | 32 | Divisor |
| quotient | output | 32 | Last committed quotient |
| remainder | output | 32 | Last committed remainder |
| done | output | 1 | One-cycle pulse when an operation ends |
| fault | output | 1 | One-cycle pulse with done when a divide error occurred |

## Verification
The end of an operation and the raising of a fault can land in the same cycle, and the result commit must then be suppressed. The bench provokes this with early faults: zero divisors, an upper word equal to the divisor, and the most negative signed dividend. It also provokes it with late range faults, where the signed quotient lands on +0x80000000 or 0x80000001. In each of these cases it checks that fault coincides with done at the expected edge. It also checks that quotient and remainder equal the values from the previous successful operation.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RUN,
        ST_FIX
    } wdiv_state_e;
endpackage

// File: rtl/wdiv_precheck.sv
module wdiv_precheck #(
    parameter int W = 32
) (
    input  logic         sgn,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] dv,
    output logic         fault_early,
    output logic [W-1:0] mag_hi,
    output logic [W-1:0] mag_lo,
    output logic [W-1:0] mag_dv,
    output logic         neg_q,
    output logic         neg_r
);
    localparam logic [2*W-1:0] MIN_DVD = {1'b1, {(2*W-1){1'b0}}};

    logic [2*W-1:0] dvd;
    logic [2*W-1:0] dvd_abs;
    logic           dvd_neg;
    logic           dv_neg;

    always_comb begin
        dvd     = {hi, lo};
        dvd_neg = sgn & hi[W-1];
        dv_neg  = sgn & dv[W-1];
        dvd_abs = dvd_neg ? (~dvd + 1'b1) : dvd;
        mag_hi  = dvd_abs[2*W-1:W];
        mag_lo  = dvd_abs[W-1:0];
        mag_dv  = dv_neg ? (~dv + 1'b1) : dv;
        neg_q   = dvd_neg ^ dv_neg;
        neg_r   = dvd_neg;
        // most negative signed dividend, zero divisor, or quotient wider than W bits
        fault_early = (sgn && dvd == MIN_DVD) || (dv == '0) || (mag_hi >= mag_dv);
    end
endmodule

// File: rtl/wdiv_iter.sv
module wdiv_iter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] dv,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         last
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  rem;
        logic [W-1:0]  acc;
        logic [W-1:0]  dv;
        logic [CW-1:0] cnt;
    } iter_t;

    iter_t    r_d, r_q;
    logic [W:0] trial;
    logic [W:0] diff;
    logic       qbit;

    always_comb begin
        r_d   = r_q;
        trial = {r_q.rem, r_q.acc[W-1]};
        diff  = trial - {1'b0, r_q.dv};
        qbit  = (trial >= {1'b0, r_q.dv});
        if (load) begin
            r_d.rem = hi;
            r_d.acc = lo;
            r_d.dv  = dv;
            r_d.cnt = CW'(W);
        end else if (r_q.cnt != '0) begin
            r_d.rem = qbit ? diff[W-1:0] : trial[W-1:0];
            r_d.acc = {r_q.acc[W-2:0], qbit};
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign quo  = r_q.acc;
    assign rem  = r_q.rem;
    assign last = (r_q.cnt == CW'(1));

    // R1: the partial remainder stays below the divisor while steps remain
    assert_rem_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cnt != '0) |-> (r_q.rem < r_q.dv));
endmodule

// File: rtl/wdiv_signfix.sv
module wdiv_signfix #(
    parameter int W = 32
) (
    input  logic         sgn,
    input  logic         neg_q,
    input  logic         neg_r,
    input  logic [W-1:0] q_mag,
    input  logic [W-1:0] r_mag,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         range_fault
);
    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        if (!sgn) begin
            quo         = q_mag;
            rem         = r_mag;
            range_fault = 1'b0;
        end else begin
            quo         = neg_q ? (~q_mag + 1'b1) : q_mag;
            rem         = neg_r ? (~r_mag + 1'b1) : r_mag;
            range_fault = neg_q ? (q_mag > HALF) : q_mag[W-1];
        end
    end

    // R6: an in-range non-zero signed quotient carries the expected sign
    always_comb begin
        if (sgn && !range_fault && q_mag != '0)
            assert_quot_sign_R6: assert (quo[W-1] == neg_q);
    end
endmodule

// File: rtl/wide_divider.sv
module wide_divider
    import wdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         signed_mode,
    input  logic [W-1:0] dividend_hi,
    input  logic [W-1:0] dividend_lo,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         done,
    output logic         fault
);
    localparam int LW = $clog2(W + 4) + 1;

    typedef struct packed {
        wdiv_state_e  st;
        logic         sgn;
        logic [W-1:0] hi;
        logic [W-1:0] lo;
        logic [W-1:0] dv;
        logic [W-1:0] quo;
        logic [W-1:0] rem;
        logic         done;
        logic         fault;
    } top_t;

    top_t         r_d, r_q;
    logic         load;
    logic         fault_early;
    logic [W-1:0] mag_hi, mag_lo, mag_dv;
    logic         neg_q, neg_r;
    logic [W-1:0] core_quo, core_rem;
    logic         core_last;
    logic [W-1:0] fix_quo, fix_rem;
    logic         range_fault;

    wdiv_precheck #(.W(W)) u_precheck (
        .sgn         (r_q.sgn),
        .hi          (r_q.hi),
        .lo          (r_q.lo),
        .dv          (r_q.dv),
        .fault_early (fault_early),
        .mag_hi      (mag_hi),
        .mag_lo      (mag_lo),
        .mag_dv      (mag_dv),
        .neg_q       (neg_q),
        .neg_r       (neg_r)
    );

    wdiv_iter #(.W(W)) u_iter (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .hi    (mag_hi),
        .lo    (mag_lo),
        .dv    (mag_dv),
        .quo   (core_quo),
        .rem   (core_rem),
        .last  (core_last)
    );

    wdiv_signfix #(.W(W)) u_signfix (
        .sgn         (r_q.sgn),
        .neg_q       (neg_q),
        .neg_r       (neg_r),
        .q_mag       (core_quo),
        .r_mag       (core_rem),
        .quo         (fix_quo),
        .rem         (fix_rem),
        .range_fault (range_fault)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.fault = 1'b0;
        load      = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.sgn = signed_mode;
                    r_d.hi  = dividend_hi;
                    r_d.lo  = dividend_lo;
                    r_d.dv  = divisor;
                    r_d.st  = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (fault_early) begin
                    r_d.done  = 1'b1;
                    r_d.fault = 1'b1;
                    r_d.st    = ST_IDLE;
                end else begin
                    load   = 1'b1;
                    r_d.st = ST_RUN;
                end
            end
            ST_RUN: begin
                if (core_last) r_d.st = ST_FIX;
            end
            ST_FIX: begin
                r_d.done = 1'b1;
                if (range_fault) begin
                    r_d.fault = 1'b1;
                end else begin
                    r_d.quo = fix_quo;
                    r_d.rem = fix_rem;
                end
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign quotient  = r_q.quo;
    assign remainder = r_q.rem;
    assign done      = r_q.done;
    assign fault     = r_q.fault;

    // cycle counter used only by the latency assertions below
    logic [LW-1:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            lat_q <= '0;
        else if (r_q.st == ST_IDLE && start)   lat_q <= LW'(1);
        else if (r_q.st != ST_IDLE)            lat_q <= lat_q + 1'b1;
    end

    assert_fault_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done);

    assert_fault_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (lat_q == LW'(2) || lat_q == LW'(W + 3)));

    assert_done_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (lat_q == LW'(W + 3)));

    assert_hold_on_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ($stable(quotient) && $stable(remainder)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_operands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |=> ($stable(r_q.hi) && $stable(r_q.lo) &&
                                 $stable(r_q.dv) && $stable(r_q.sgn)));
endmodule

// File: tb/wide_divider_bench.sv
module wide_divider_bench;
    localparam int W  = 32;
    localparam int NV = 18;
    localparam int LATE = W + 3;

    typedef struct packed {
        logic        sgn;
        logic [31:0] hi;
        logic [31:0] lo;
        logic [31:0] dv;
        logic        flt;
        logic [7:0]  lat;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{1'b0, 32'h0000_0000, 32'h0000_0064, 32'h0000_0007, 1'b0, 8'd35},
        '{1'b0, 32'h0000_0001, 32'h0000_0000, 32'h0000_0002, 1'b0, 8'd35},
        '{1'b0, 32'h0000_0005, 32'h0000_0000, 32'h0000_0005, 1'b1, 8'd2},
        '{1'b0, 32'h0000_0000, 32'h0000_0005, 32'h0000_0000, 1'b1, 8'd2},
        '{1'b0, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 8'd35},
        '{1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000, 1'b0, 8'd35},
        '{1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'h0000_0002, 1'b0, 8'd35},
        '{1'b1, 32'h0000_0000, 32'h0000_0007, 32'hFFFF_FFFE, 1'b0, 8'd35},
        '{1'b1, 32'h0000_0000, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 8'd35},
        '{1'b1, 32'h0000_0000, 32'h8000_0000, 32'h0000_0001, 1'b1, 8'd35},
        '{1'b1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0001, 1'b0, 8'd35},
        '{1'b1, 32'h0000_0000, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 8'd35},
        '{1'b1, 32'hFFFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 8'd35},
        '{1'b1, 32'h8000_0000, 32'h0000_0000, 32'h0000_0000, 1'b1, 8'd2},
        '{1'b1, 32'h8000_0000, 32'h0000_0000, 32'h0000_0005, 1'b1, 8'd2},
        '{1'b1, 32'h0000_0005, 32'h0000_0000, 32'h0000_0000, 1'b1, 8'd2},
        '{1'b1, 32'h3FFF_FFFF, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b1, 8'd35},
        '{1'b0, 32'h1234_5678, 32'h9ABC_DEF0, 32'hFEDC_BA98, 1'b0, 8'd35}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        signed_mode = 1'b0;
    logic [31:0] dividend_hi = '0;
    logic [31:0] dividend_lo = '0;
    logic [31:0] divisor = '0;
    logic [31:0] quotient, remainder;
    logic        done, fault;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    wide_divider #(.W(W)) u_wide_divider (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .signed_mode (signed_mode),
        .dividend_hi (dividend_hi),
        .dividend_lo (dividend_lo),
        .divisor     (divisor),
        .quotient    (quotient),
        .remainder   (remainder),
        .done        (done),
        .fault       (fault)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // behavioural model written from the requirements
    task automatic ref_div(input logic sgn, input logic [31:0] hi, input logic [31:0] lo,
                           input logic [31:0] dv, output logic flt,
                           output logic [31:0] q, output logic [31:0] r);
        logic [63:0] u;
        logic [63:0] uq, ur;
        longint sd, sv, sq, sr;
        u = {hi, lo};
        flt = 1'b0; q = '0; r = '0;
        if (!sgn) begin
            if (dv == 0) flt = 1'b1;
            else begin
                uq = u / {32'h0, dv};
                ur = u % {32'h0, dv};
                flt = (uq[63:32] != 0);
                q = uq[31:0]; r = ur[31:0];
            end
        end else begin
            if (u == 64'h8000_0000_0000_0000) flt = 1'b1;
            else if (dv == 0) flt = 1'b1;
            else begin
                sd = longint'(u);
                sv = longint'($signed(dv));
                sq = sd / sv;
                sr = sd % sv;
                flt = (sq > 64'sd2147483647) || (sq < -64'sd2147483648);
                q = sq[31:0]; r = sr[31:0];
            end
        end
    endtask

    task automatic run_op(input logic sgn, input logic [31:0] hi, input logic [31:0] lo,
                          input logic [31:0] dv, output int n);
        @(negedge clk);
        signed_mode = sgn; dividend_hi = hi; dividend_lo = lo; divisor = dv;
        start = 1'b1;
        @(posedge clk);
        n = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done && n < 100) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
    endtask

    function automatic string tag_of(vec_t v, logic rflt);
        if (!rflt) return v.sgn ? "R6" : "R1";
        if (v.sgn && {v.hi, v.lo} == 64'h8000_0000_0000_0000) return "R4";
        if (v.dv == 0) return "R2";
        return v.sgn ? "R5" : "R3";
    endfunction

    task automatic check_op(input vec_t v, input logic use_tbl);
        logic [31:0] pq, pr, eq, er;
        logic ef;
        int n;
        string tg;
        pq = quotient; pr = remainder;
        ref_div(v.sgn, v.hi, v.lo, v.dv, ef, eq, er);
        tg = tag_of(v, ef);
        run_op(v.sgn, v.hi, v.lo, v.dv, n);
        if (use_tbl) begin
            chk({tg, " fault flag"}, 64'(fault), 64'(v.flt));
            chk(v.flt && v.lat == 8'd2 ? "R8 early latency" : "R9 latency", 64'(n), 64'(v.lat));
        end else begin
            chk({tg, " fault flag"}, 64'(fault), 64'(ef));
            if (!ef) chk("R9 latency", 64'(n), 64'(LATE));
        end
        chk("R8 done with fault", 64'(done), 64'd1);
        if (ef) begin
            chk("R7 quotient held", 64'(quotient), 64'(pq));
            chk("R7 remainder held", 64'(remainder), 64'(pr));
        end else begin
            chk({tg, " quotient"}, 64'(quotient), 64'(eq));
            chk({tg, " remainder"}, 64'(remainder), 64'(er));
        end
        @(posedge clk);
        @(negedge clk);
        chk("R11 done pulse", 64'({done, fault}), 64'd0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk("R11 reset done", 64'({done, fault}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset quotient", 64'(quotient), 64'd0);
        chk("R11 reset remainder", 64'(remainder), 64'd0);

        for (int i = 0; i < NV; i++) check_op(VEC[i], 1'b1);

        // R10: start re-asserted with a zero divisor during a running operation
        @(negedge clk);
        signed_mode = 1'b0; dividend_hi = 32'h0; dividend_lo = 32'd100; divisor = 32'd7;
        start = 1'b1;
        @(posedge clk);
        n = 1;
        @(negedge clk);
        dividend_lo = 32'd50; divisor = 32'd0;
        while (!done && n < 100) begin
            if (n > 6) start = 1'b0;
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        start = 1'b0;
        chk("R10 latency", 64'(n), 64'(LATE));
        chk("R10 fault", 64'(fault), 64'd0);
        chk("R10 quotient", 64'(quotient), 64'd14);
        chk("R10 remainder", 64'(remainder), 64'd2);
        repeat (2) @(negedge clk);

        for (int k = 0; k < 30; k++) begin
            vec_t v;
            v.sgn = 1'($urandom);
            v.dv  = $urandom >> ($urandom % 32);
            v.hi  = $urandom >> ($urandom % 33);
            v.lo  = $urandom;
            v.flt = 1'b0;
            v.lat = 8'd0;
            check_op(v, 1'b0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule